// File: doc/BRIEF.md
# Masked Ternary Lookup Engine

This block is a small content-addressable table of 64-bit entries with a pending-operation queue in front of it. A single global mask decides which key bits take part in every comparison: a mask bit of 0 makes the bit significant and a mask bit of 1 makes it don't-care. A lookup presents a 64-bit key. The engine answers with a hit flag and the low 32 bits of the matched entry, or with a miss and zero data.

Insert and delete operations enter a first-in first-out queue. Queued operations count toward lookups at once, and the newest operation on a key takes precedence over older queued operations and over the table. The queue moves into the table one operation per idle cycle. An insert whose masked key matches a stored entry replaces that entry. The engine also reports a live entry count and an almost-full flag.

An optional ATM mode treats bits 59:48 as a path identifier and bits 47:32 as a circuit identifier. An entry whose circuit field is all ones acts as a path entry. A path entry answers any key that carries its path identifier, and the hit then also raises a path flag. Inserting a circuit entry replaces a path entry that has the same path identifier. Deleting a circuit entry that is not stored removes the path entry that has the same path identifier.

Top module: `mtl_engine`

## Requirements
- R1: A lookup hits an entry when `((key ^ entry) & ~cfg_mask) == 0`. A mask bit of 1 makes that key bit don't-care, and a mask bit of 0 makes it significant.
- R2: When `lk_valid` is sampled high at a clock edge, `res_valid` is high for exactly one cycle after the second edge from that one. On a hit, `res_data` carries bits 31:0 of the matched entry.
- R3: On a miss, `res_hit` is 0, `res_path` is 0 and `res_data` is 0. After reset, `res_valid`, `op_err` and `entry_count` are all 0.
- R4: The pending queue holds 14 operations. An operation presented while 14 are pending is dropped, the queue does not change, and `op_err` is 1 for the one cycle after that edge.
- R5: Queued operations take part in lookups from the cycle after they are accepted. The newest operation on a key wins: if an insert is followed by a delete, the lookup misses; if a delete is followed by an insert, the lookup hits; a queued delete hides an entry that is in the table.
- R6: When a queued insert is moved into the table and its masked key matches a valid entry, it replaces that entry, so only one entry exists per masked key.
- R7: `entry_count` equals the valid table entries plus the pending inserts. It changes in the cycle after an operation is accepted.
- R8: `almost_full` is 1 when the count of valid table entries is at least `cfg_afull_pt`. Pending queue operations are not included in this count.
- R9: With `cfg_atm` set, a key hits an entry whose bits 47:32 are 0xFFFF when all significant bits outside 47:32 agree. This path hit raises both `res_hit` and `res_path`. A circuit hit on an ordinary entry keeps `res_path` at 0.
- R10: With `cfg_atm` set, inserting a circuit entry whose path identifier (bits 59:48) matches a stored path entry replaces that path entry.
- R11: With `cfg_atm` set, deleting a circuit entry that is not stored removes the path entry that has the same path identifier. Deleting a key that matches nothing has no effect.
- R12: Queued operations move into the table in first-in order, one per cycle. This happens only when `op_valid`, `lk_valid` and the registered lookup stage are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mask | input | 64 | Global compare mask; 1 means don't-care |
| cfg_atm | input | 1 | Enables path and circuit matching |
| cfg_afull_pt | input | 6 | Almost-full threshold on the table entry count |
| op_valid | input | 1 | Presents one insert or delete operation |
| op_del | input | 1 | 0 = insert, 1 = delete |
| op_entry | input | 64 | Entry, or key, for the operation |
| op_err | output | 1 | The previous cycle's operation was dropped because the queue was full |
| lk_valid | input | 1 | Presents a lookup key |
| lk_key | input | 64 | Lookup key |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Lookup found an entry |
| res_path | output | 1 | The hit came from a path entry in ATM mode |
| res_data | output | 32 | Low 32 bits of the matched entry, or zero |
| entry_count | output | 6 | Valid table entries plus pending inserts |
| almost_full | output | 1 | Table entry count has reached the threshold |

## Verification
The bench times operations back to back so that conflicting inserts and deletes are still pending when a lookup samples them. A design that let the table win over the queue, or the older queued operation win over the newer one, would report stale hits or misses. It fills the queue to 14 and offers a fifteenth operation. A design with an off-by-one depth would accept it, or would fail to raise the error and corrupt the count. The ATM cases insert path entries and then replace or delete them through circuit keys. A design that skipped the path fallback would keep a stale path entry and return old data on keys that should now miss. The bench also reads the count and almost-full flag while an insert is still queued, which exposes a design that includes pending operations in the table-only threshold.

// File: rtl/mtl_pkg.sv
package mtl_pkg;

    localparam int KEY_W  = 64;
    localparam int DATA_W = 32;

    typedef logic [KEY_W-1:0] entry_t;

    typedef struct packed {
        logic   del;
        entry_t ent;
    } qitem_t;

    // Bits 47:32 hold the circuit identifier in ATM mode
    localparam entry_t CIRC_FIELD = 64'h0000_FFFF_0000_0000;

    function automatic logic key_eq(entry_t a, entry_t b, entry_t mask);
        return ((a ^ b) & ~mask) == '0;
    endfunction

    function automatic logic is_path_entry(entry_t e);
        return e[47:32] == 16'hFFFF;
    endfunction

    // Path-level equality: the circuit field of the key is ignored
    function automatic logic path_eq(entry_t key, entry_t ent, entry_t mask, logic atm);
        return atm && is_path_entry(ent) && (((key ^ ent) & ~mask & ~CIRC_FIELD) == '0);
    endfunction

endpackage

// File: rtl/mtl_queue.sv
module mtl_queue
    import mtl_pkg::*;
#(
    parameter int DEPTH = 14,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  qitem_t        push_item,
    input  logic          pop,
    output qitem_t        items [DEPTH],
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic [CW-1:0] ins_cnt
);

    assign full = (cnt == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) items[i] <= '0;
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == cnt) items[i] <= push_item;
            cnt <= cnt + 1'b1;
        end else if (pop && cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) items[i] <= items[i+1];
            items[DEPTH-1] <= '0;
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        ins_cnt = '0;
        for (int i = 0; i < DEPTH; i++)
            if (CW'(i) < cnt && !items[i].del) ins_cnt = ins_cnt + 1'b1;
    end

endmodule

// File: rtl/mtl_table.sv
module mtl_table
    import mtl_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply,
    input  qitem_t           item,
    input  entry_t           mask,
    input  logic             atm,
    output entry_t           ents [DEPTH],
    output logic [DEPTH-1:0] vld,
    output logic [CW-1:0]    vcount
);

    logic          ex_found, pa_found, fr_found;
    logic [IW-1:0] ex_idx, pa_idx, fr_idx;

    always_comb begin
        ex_found = 1'b0; ex_idx = '0;
        pa_found = 1'b0; pa_idx = '0;
        fr_found = 1'b0; fr_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ex_found && vld[i] && key_eq(item.ent, ents[i], mask)) begin
                ex_found = 1'b1; ex_idx = IW'(i);
            end
            if (!pa_found && vld[i] && path_eq(item.ent, ents[i], mask, atm)) begin
                pa_found = 1'b1; pa_idx = IW'(i);
            end
            if (!fr_found && !vld[i]) begin
                fr_found = 1'b1; fr_idx = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else if (apply) begin
            if (!item.del) begin
                if (ex_found) begin
                    ents[ex_idx] <= item.ent;
                end else if (pa_found) begin
                    ents[pa_idx] <= item.ent;
                end else if (fr_found) begin
                    ents[fr_idx] <= item.ent;
                    vld[fr_idx]  <= 1'b1;
                end
            end else begin
                if (ex_found)      vld[ex_idx] <= 1'b0;
                else if (pa_found) vld[pa_idx] <= 1'b0;
            end
        end
    end

    always_comb begin
        vcount = '0;
        for (int i = 0; i < DEPTH; i++) vcount = vcount + CW'(vld[i]);
    end

endmodule

// File: rtl/mtl_resolve.sv
module mtl_resolve
    import mtl_pkg::*;
#(
    parameter int TDEPTH = 32,
    parameter int QDEPTH = 14,
    localparam int QCW = $clog2(QDEPTH + 1)
) (
    input  entry_t            key,
    input  entry_t            mask,
    input  logic              atm,
    input  entry_t            tbl_ents [TDEPTH],
    input  logic [TDEPTH-1:0] tbl_vld,
    input  qitem_t            q_items [QDEPTH],
    input  logic [QCW-1:0]    q_cnt,
    output logic              hit,
    output logic              path,
    output entry_t            ent
);

    logic   c_hit, p_hit;
    entry_t c_ent, p_ent;

    always_comb begin
        c_hit = 1'b0; c_ent = '0;
        p_hit = 1'b0; p_ent = '0;
        for (int i = 0; i < TDEPTH; i++) begin
            if (tbl_vld[i] && key_eq(key, tbl_ents[i], mask)) begin
                c_hit = 1'b1; c_ent = tbl_ents[i];
            end
            if (tbl_vld[i] && path_eq(key, tbl_ents[i], mask, atm)) begin
                p_hit = 1'b1; p_ent = tbl_ents[i];
            end
        end
        // Oldest to newest: the latest matching operation decides
        for (int j = 0; j < QDEPTH; j++) begin
            if (QCW'(j) < q_cnt) begin
                if (key_eq(key, q_items[j].ent, mask)) begin
                    c_hit = !q_items[j].del; c_ent = q_items[j].ent;
                end
                if (path_eq(key, q_items[j].ent, mask, atm)) begin
                    p_hit = !q_items[j].del; p_ent = q_items[j].ent;
                end
            end
        end
        hit  = c_hit || p_hit;
        ent  = c_hit ? c_ent : (p_hit ? p_ent : '0);
        path = c_hit ? (atm && is_path_entry(c_ent)) : p_hit;
    end

endmodule

// File: rtl/mtl_engine.sv
module mtl_engine
    import mtl_pkg::*;
#(
    parameter int TBL_DEPTH = 32,
    parameter int Q_DEPTH   = 14,
    localparam int CNT_W = $clog2(TBL_DEPTH + Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       cfg_mask,
    input  logic              cfg_atm,
    input  logic [CNT_W-1:0]  cfg_afull_pt,
    input  logic              op_valid,
    input  logic              op_del,
    input  logic [63:0]       op_entry,
    output logic              op_err,
    input  logic              lk_valid,
    input  logic [63:0]       lk_key,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_path,
    output logic [31:0]       res_data,
    output logic [CNT_W-1:0]  entry_count,
    output logic              almost_full
);

    localparam int QCW = $clog2(Q_DEPTH + 1);
    localparam int TCW = $clog2(TBL_DEPTH + 1);

    qitem_t                q_items [Q_DEPTH];
    logic [QCW-1:0]        q_cnt, q_ins;
    logic                  q_full;
    entry_t                tbl_ents [TBL_DEPTH];
    logic [TBL_DEPTH-1:0]  tbl_vld;
    logic [TCW-1:0]        tbl_cnt;

    logic   s1_vld;
    entry_t s1_key;
    logic   r_hit, r_path;
    entry_t r_ent;
    logic   drain;
    qitem_t new_item;

    assign new_item = '{del: op_del, ent: op_entry};
    assign drain = !op_valid && !lk_valid && !s1_vld && (q_cnt != '0);

    mtl_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .push(op_valid), .push_item(new_item), .pop(drain),
        .items(q_items), .cnt(q_cnt), .full(q_full), .ins_cnt(q_ins)
    );

    mtl_table #(.DEPTH(TBL_DEPTH)) u_table (
        .clk(clk), .rst(rst),
        .apply(drain), .item(q_items[0]), .mask(cfg_mask), .atm(cfg_atm),
        .ents(tbl_ents), .vld(tbl_vld), .vcount(tbl_cnt)
    );

    mtl_resolve #(.TDEPTH(TBL_DEPTH), .QDEPTH(Q_DEPTH)) u_resolve (
        .key(s1_key), .mask(cfg_mask), .atm(cfg_atm),
        .tbl_ents(tbl_ents), .tbl_vld(tbl_vld),
        .q_items(q_items), .q_cnt(q_cnt),
        .hit(r_hit), .path(r_path), .ent(r_ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld    <= 1'b0;
            s1_key    <= '0;
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_path  <= 1'b0;
            res_data  <= '0;
            op_err    <= 1'b0;
        end else begin
            s1_vld    <= lk_valid;
            if (lk_valid) s1_key <= lk_key;
            res_valid <= s1_vld;
            res_hit   <= s1_vld && r_hit;
            res_path  <= s1_vld && r_path;
            res_data  <= (s1_vld && r_hit) ? r_ent[DATA_W-1:0] : '0;
            op_err    <= op_valid && q_full;
        end
    end

    assign entry_count = CNT_W'(tbl_cnt) + CNT_W'(q_ins);
    assign almost_full = CNT_W'(tbl_cnt) >= cfg_afull_pt;

endmodule

// File: rtl/mtl_engine_chk.sv
module mtl_engine_chk #(
    parameter int TD  = 32,
    parameter int QD  = 14,
    parameter int CW  = 6,
    parameter int QCW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          lk_valid,
    input logic          op_valid,
    input logic          cfg_atm,
    input logic          res_valid,
    input logic          res_hit,
    input logic          res_path,
    input logic [31:0]   res_data,
    input logic          q_full,
    input logic [QCW-1:0] q_cnt,
    input logic [CW-1:0] entry_count
);

    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> ##2 res_valid); // R2

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_data == '0 && !res_path)); // R3

    AST_PATH_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        res_path |-> (res_hit && cfg_atm)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        q_cnt <= QCW'(QD)); // R4

    AST_REJECT_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && q_full) |=> (q_cnt == $past(q_cnt))); // R4

    AST_LOOKUP_BLOCKS_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !op_valid) |=> (q_cnt == $past(q_cnt))); // R12

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        entry_count <= CW'(TD + QD)); // R7

endmodule

bind mtl_engine mtl_engine_chk #(
    .TD(TBL_DEPTH), .QD(Q_DEPTH), .CW(CNT_W), .QCW(QCW)
) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .op_valid(op_valid),
    .cfg_atm(cfg_atm), .res_valid(res_valid), .res_hit(res_hit),
    .res_path(res_path), .res_data(res_data), .q_full(q_full),
    .q_cnt(q_cnt), .entry_count(entry_count)
);

// File: tb/test_mtl_engine.sv
module test_mtl_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cfg_mask = '0;
    logic        cfg_atm = 1'b0;
    logic [5:0]  cfg_afull_pt = 6'd40;
    logic        op_valid = 1'b0, op_del = 1'b0;
    logic [63:0] op_entry = '0;
    logic        op_err;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_key = '0;
    logic        res_valid, res_hit, res_path;
    logic [31:0] res_data;
    logic [5:0]  entry_count;
    logic        almost_full;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mtl_engine i_mtl_engine (
        .clk(clk), .rst(rst), .cfg_mask(cfg_mask), .cfg_atm(cfg_atm),
        .cfg_afull_pt(cfg_afull_pt), .op_valid(op_valid), .op_del(op_del),
        .op_entry(op_entry), .op_err(op_err), .lk_valid(lk_valid),
        .lk_key(lk_key), .res_valid(res_valid), .res_hit(res_hit),
        .res_path(res_path), .res_data(res_data),
        .entry_count(entry_count), .almost_full(almost_full)
    );

    typedef struct {
        logic        hit;
        logic        path;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst && res_valid && !done) begin
            if (sb.size() == 0) begin
                chk("R2 unexpected result", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " hit"},  {63'd0, res_hit},  {63'd0, e.hit});
                chk({e.tag, " path"}, {63'd0, res_path}, {63'd0, e.path});
                chk({e.tag, " data"}, {32'd0, res_data}, {32'd0, e.data});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0; lk_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_op(logic del, logic [63:0] ent);
        @(negedge clk);
        op_valid = 1'b1; op_del = del; op_entry = ent;
    endtask

    task automatic do_lookup(logic [63:0] key, logic hit, logic path,
                             logic [31:0] data, string tag);
        exp_t e;
        e.hit = hit; e.path = path; e.data = data; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        op_valid = 1'b0; lk_valid = 1'b1; lk_key = key;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        op_valid = 1'b0; lk_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R3 reset state
        chk("R3 reset res_valid", {63'd0, res_valid}, 64'd0);
        chk("R3 reset op_err", {63'd0, op_err}, 64'd0);
        chk("R7 reset count", {58'd0, entry_count}, 64'd0);

        // R1 mask compare, R2 latency, R5 queue visibility
        cfg_mask = 64'h0000_0000_FFFF_FFFF;
        do_op(1'b0, 64'h1234_5678_AAAA_0001);
        do_lookup(64'h1234_5678_0000_0000, 1'b1, 1'b0, 32'hAAAA_0001, "R5 queued insert visible");
        chk("R2 no result after one edge", {63'd0, res_valid}, 64'd0);
        idle(5);
        do_lookup(64'h1234_5679_0000_0000, 1'b0, 1'b0, 32'h0, "R1 significant bit differs");
        idle(3);
        cfg_mask = 64'h0000_0001_FFFF_FFFF;
        do_lookup(64'h1234_5679_0000_0000, 1'b1, 1'b0, 32'hAAAA_0001, "R1 masked bit ignored");
        idle(3);

        // R5 newest wins, R12 drain order
        do_reset();
        cfg_mask = 64'h0000_0000_FFFF_FFFF;
        do_op(1'b0, 64'hAAAA_0000_0000_0011);
        do_op(1'b1, 64'hAAAA_0000_0000_0000);
        do_lookup(64'hAAAA_0000_0000_0000, 1'b0, 1'b0, 32'h0, "R5 insert then delete");
        idle(6);
        do_lookup(64'hAAAA_0000_0000_0000, 1'b0, 1'b0, 32'h0, "R12 drained insert then delete");
        idle(2);
        do_op(1'b1, 64'hAAAA_0000_0000_0000);
        do_op(1'b0, 64'hAAAA_0000_0000_0022);
        do_lookup(64'hAAAA_0000_0000_0000, 1'b1, 1'b0, 32'h22, "R5 delete then insert");
        idle(6);
        chk("R11 absent delete no effect count", {58'd0, entry_count}, 64'd1);
        do_lookup(64'hAAAA_0000_0000_0000, 1'b1, 1'b0, 32'h22, "R12 drained delete then insert");
        idle(2);
        do_op(1'b1, 64'hAAAA_0000_0000_0000);
        do_lookup(64'hAAAA_0000_0000_0000, 1'b0, 1'b0, 32'h0, "R5 queued delete hides table");
        idle(6);
        chk("R7 count after delete", {58'd0, entry_count}, 64'd0);

        // R6 overwrite, R7 count
        do_reset();
        do_op(1'b0, 64'h5555_0000_0000_0001);
        idle(5);
        chk("R7 count one entry", {58'd0, entry_count}, 64'd1);
        do_op(1'b0, 64'h5555_0000_0000_0002);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 count includes queued insert", {58'd0, entry_count}, 64'd2);
        idle(5);
        chk("R6 count after overwrite", {58'd0, entry_count}, 64'd1);
        do_lookup(64'h5555_0000_0000_0000, 1'b1, 1'b0, 32'h2, "R6 overwritten data");
        idle(3);

        // R8 almost full uses table count only
        do_reset();
        cfg_afull_pt = 6'd3;
        do_op(1'b0, 64'h0100_0000_0000_0001);
        do_op(1'b0, 64'h0200_0000_0000_0002);
        do_op(1'b0, 64'h0300_0000_0000_0003);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 count three queued", {58'd0, entry_count}, 64'd3);
        chk("R8 queued not in almost full", {63'd0, almost_full}, 64'd0);
        idle(8);
        chk("R8 almost full reached", {63'd0, almost_full}, 64'd1);
        cfg_afull_pt = 6'd40;

        // R4 queue full
        do_reset();
        for (int i = 0; i < 14; i++)
            do_op(1'b0, (64'(i + 1) << 40) | 64'(i + 1));
        do_op(1'b0, (64'd15 << 40) | 64'd15);
        @(negedge clk);
        chk("R4 op_err on full", {63'd0, op_err}, 64'd1);
        op_valid = 1'b0;
        chk("R4 count unchanged", {58'd0, entry_count}, 64'd14);
        @(negedge clk);
        chk("R4 op_err one cycle", {63'd0, op_err}, 64'd0);
        do_lookup(64'd15 << 40, 1'b0, 1'b0, 32'h0, "R4 rejected insert absent");
        do_lookup(64'd14 << 40, 1'b1, 1'b0, 32'd14, "R4 last accepted insert");
        idle(25);
        chk("R12 all drained count", {58'd0, entry_count}, 64'd14);

        // R9, R10 ATM path matching and overwrite
        do_reset();
        cfg_atm = 1'b1;
        cfg_mask = 64'hF000_0000_FFFF_FFFF;
        do_op(1'b0, 64'h0123_FFFF_0000_D00D);
        idle(4);
        do_lookup(64'h0123_0042_0000_0000, 1'b1, 1'b1, 32'h0000_D00D, "R9 path hit");
        do_lookup(64'h0124_0042_0000_0000, 1'b0, 1'b0, 32'h0, "R9 other path misses");
        idle(2);
        do_op(1'b0, 64'h0123_0042_0000_00C1);
        idle(4);
        chk("R10 count after circuit replaces path", {58'd0, entry_count}, 64'd1);
        do_lookup(64'h0123_0042_0000_0000, 1'b1, 1'b0, 32'hC1, "R10 circuit hit");
        do_lookup(64'h0123_0050_0000_0000, 1'b0, 1'b0, 32'h0, "R10 path entry gone");
        idle(3);

        // R11 circuit delete falls back to path entry
        do_reset();
        do_op(1'b0, 64'h0200_FFFF_0000_0055);
        idle(4);
        do_op(1'b1, 64'h0200_0007_0000_0000);
        idle(4);
        chk("R11 path entry removed count", {58'd0, entry_count}, 64'd0);
        do_lookup(64'h0200_0009_0000_0000, 1'b0, 1'b0, 32'h0, "R11 path lookup misses");
        idle(4);
        cfg_atm = 1'b0;

        chk("R2 every lookup answered", 64'(sb.size()), 64'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule